// File: doc/BRIEF.md
# Branch Next-PC Resolver

This block is the combinational next-PC stage of a 32-bit processor whose instructions are all four bytes long. A decoder hands it a branch kind code, the current PC, a 24-bit signed word displacement taken from the instruction, a register operand, and the four condition flags (negative, zero, carry, overflow). From these it produces the address of the next instruction, a flag saying whether control left the sequential path, and a request to write a return address into the link register.

PC-relative targets are measured from the branch address plus eight, and the displacement counts words rather than bytes. The block handles an always-taken branch, conditions on the zero flag, signed compares on the negative and overflow flags, unsigned compares on the carry flag, a branch that also saves a return address, and a jump through a register. When a branch is not taken, and for any code with no branch meaning, the PC moves on by one instruction.

The block holds no state. It sits between the decoder and the PC register, and its outputs are settled within the same cycle its inputs are.

Top module: `branch_next_pc`

## Requirements
- R1: When a PC-relative branch is taken, next_pc equals cur_pc + 8 + 4 × br_disp, where br_disp is read as a signed 24-bit number.
- R2: When a conditional branch is not taken, next_pc equals cur_pc + 4 and br_taken is 0.
- R3: Code 2 (equal) is taken exactly when flag_z is 1. Code 3 (not equal) is taken exactly when flag_z is 0.
- R4: Code 4 (signed less-than) is taken when flag_n differs from flag_v. Code 5 (signed greater-or-equal) is taken when they match.
- R5: Code 6 (unsigned higher-or-same) is taken when flag_c is 1. Code 7 (unsigned lower) is taken when flag_c is 0.
- R6: Code 1 (always) is taken for every flag setting. A displacement of -2 sends next_pc to cur_pc itself.
- R7: Code 8 (branch with link) is always taken to the relative target, drives link_we to 1 and link_val to cur_pc + 4. link_we is 0 for every other code.
- R8: Code 9 (register jump) is always taken. next_pc equals jump_reg with bits 1:0 forced to zero, and the flags and displacement have no effect.
- R9: Code 0 and codes 10 to 15 are never taken and give next_pc = cur_pc + 4, whatever the flags.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 32 | Address of the branch instruction |
| br_kind | input | 4 | Branch kind code (see requirements) |
| br_disp | input | 24 | Signed word displacement |
| jump_reg | input | 32 | Register operand for the register jump |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| next_pc | output | 32 | Address of the next instruction |
| br_taken | output | 1 | Control left the sequential path |
| link_we | output | 1 | Write link_val into the link register |
| link_val | output | 32 | Return address |

## Verification
The block has no memory, so any internal fault appears at the ports in the same cycle as the input that exposes it. A wrong condition decode shows as a br_taken value that disagrees with the flags, and next_pc lands on the other of its two candidates. A wrong offset base or scale moves next_pc by a fixed number of bytes. A missing alignment mask leaves low bits set on a register jump. A bad sign extension is visible only for negative displacements, so those are tested both near zero and at the wrap boundary.

// File: rtl/bnp_pkg.sv
package bnp_pkg;
  localparam int ADDR_W = 32;
  localparam int DISP_W = 24;
  localparam int KIND_W = 4;
  localparam int INSTR_BYTES = 4;
  localparam int PIPE_AHEAD = 8;
  localparam int SCALE_SH = $clog2(INSTR_BYTES);

  typedef enum logic [KIND_W-1:0] {
    K_NONE = 4'd0,
    K_ALWAYS = 4'd1,
    K_EQ = 4'd2,
    K_NE = 4'd3,
    K_LT = 4'd4,
    K_GE = 4'd5,
    K_HS = 4'd6,
    K_LO = 4'd7,
    K_LINK = 4'd8,
    K_JREG = 4'd9
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Sequential successor: one instruction further on.
  function automatic logic [ADDR_W-1:0] seq_succ(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INSTR_BYTES);
  endfunction

  // Relative target: read-ahead base plus displacement scaled to bytes.
  function automatic logic [ADDR_W-1:0] rel_dest(input logic [ADDR_W-1:0] pc,
                                                 input logic [DISP_W-1:0] d);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-DISP_W-SCALE_SH){d[DISP_W-1]}}, d, {SCALE_SH{1'b0}}};
    return pc + ADDR_W'(PIPE_AHEAD) + ext;
  endfunction

  // Register target aligned down to an instruction boundary.
  function automatic logic [ADDR_W-1:0] reg_dest(input logic [ADDR_W-1:0] r);
    return {r[ADDR_W-1:SCALE_SH], {SCALE_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/bnp_cond_eval.sv
module bnp_cond_eval
  import bnp_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  flags_t            flags,
  output logic              take,
  output logic              use_rel,
  output logic              use_reg,
  output logic              do_link
);
  logic signed_lt;
  assign signed_lt = flags.n ^ flags.v;

  always_comb begin
    take    = 1'b0;
    use_rel = 1'b0;
    use_reg = 1'b0;
    do_link = 1'b0;
    case (kind)
      K_ALWAYS: begin take = 1'b1; use_rel = 1'b1; end
      K_EQ:     begin take = flags.z;    use_rel = 1'b1; end
      K_NE:     begin take = !flags.z;   use_rel = 1'b1; end
      K_LT:     begin take = signed_lt;  use_rel = 1'b1; end
      K_GE:     begin take = !signed_lt; use_rel = 1'b1; end
      K_HS:     begin take = flags.c;    use_rel = 1'b1; end
      K_LO:     begin take = !flags.c;   use_rel = 1'b1; end
      K_LINK:   begin take = 1'b1; use_rel = 1'b1; do_link = 1'b1; end
      K_JREG:   begin take = 1'b1; use_reg = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    if (kind == K_EQ && take) assert_eq_needs_z_R3: assert (flags.z);
    if (kind == K_LT && take) assert_lt_needs_nv_differ_R4: assert (flags.n != flags.v);
    if (kind == K_LO && take) assert_lo_needs_clear_c_R5: assert (!flags.c);
    assert_one_source_R9: assert (!(use_rel && use_reg));
  end
endmodule

// File: rtl/bnp_target_gen.sv
module bnp_target_gen
  import bnp_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] rval,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [ADDR_W-1:0] reg_addr
);
  assign seq_addr = seq_succ(pc);
  assign rel_addr = rel_dest(pc, disp);
  assign reg_addr = reg_dest(rval);

  always_comb begin
    assert_self_loop_R6: assert (!(disp == '1 - DISP_W'(1)) || rel_addr == pc);
    assert_seq_distance_R2: assert (seq_addr - pc == ADDR_W'(INSTR_BYTES));
  end
endmodule

// File: rtl/branch_next_pc.sv
module branch_next_pc
  import bnp_pkg::*;
(
  input  logic [31:0] cur_pc,
  input  logic [3:0]  br_kind,
  input  logic [23:0] br_disp,
  input  logic [31:0] jump_reg,
  input  logic        flag_n,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic        flag_v,
  output logic [31:0] next_pc,
  output logic        br_taken,
  output logic        link_we,
  output logic [31:0] link_val
);
  flags_t            flg;
  logic              take_w, rel_sel_w, reg_sel_w, link_w;
  logic [ADDR_W-1:0] seq_w, rel_w, reg_w;

  assign flg = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  bnp_cond_eval u_cond (
    .kind    (br_kind),
    .flags   (flg),
    .take    (take_w),
    .use_rel (rel_sel_w),
    .use_reg (reg_sel_w),
    .do_link (link_w)
  );

  bnp_target_gen u_tgt (
    .pc       (cur_pc),
    .disp     (br_disp),
    .rval     (jump_reg),
    .seq_addr (seq_w),
    .rel_addr (rel_w),
    .reg_addr (reg_w)
  );

  always_comb begin
    next_pc = seq_w;
    if (take_w && reg_sel_w)      next_pc = reg_w;
    else if (take_w && rel_sel_w) next_pc = rel_w;
  end

  assign br_taken = take_w;
  assign link_we  = link_w;
  assign link_val = seq_w;

  always_comb begin
    if (!br_taken) assert_fallthrough_R2: assert (next_pc == seq_w);
    if (link_we) assert_link_taken_R7: assert (br_taken && link_val == seq_w);
    if (reg_sel_w) assert_jump_aligned_R8: assert (next_pc[1:0] == 2'b00 && br_taken);
  end
endmodule

// File: tb/branch_next_pc_test.sv
module branch_next_pc_test;
  logic        clk = 1'b0;
  logic [31:0] cur_pc = '0, jump_reg = '0;
  logic [3:0]  br_kind = '0;
  logic [23:0] br_disp = '0;
  logic        flag_n = 0, flag_z = 0, flag_c = 0, flag_v = 0;
  logic [31:0] next_pc, link_val;
  logic        br_taken, link_we;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_next_pc uut (.*);

  function automatic logic [31:0] exp_rel(input logic [31:0] pc, input logic [23:0] d);
    int s;
    s = int'($signed(d));
    return pc + 32'd8 + 32'(s * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic [31:0] pc, input logic [23:0] d,
                       input logic [31:0] r, input logic [3:0] nzcv);
    @(negedge clk);
    br_kind = k; cur_pc = pc; br_disp = d; jump_reg = r;
    {flag_n, flag_z, flag_c, flag_v} = nzcv;
    #2;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] np, input logic tk, input logic lw);
    chk({tag, " next_pc"}, next_pc, np);
    chk({tag, " taken"}, {31'd0, br_taken}, {31'd0, tk});
    chk({tag, " link_we"}, {31'd0, link_we}, {31'd0, lw});
  endtask

  task automatic t_always_R6();
    for (int f = 0; f < 16; f++) begin
      drive(4'd1, 32'h0000_1000, 24'd5, '0, 4'(f));
      expect_out("R6 always", exp_rel(32'h1000, 24'd5), 1, 0);
    end
    drive(4'd1, 32'h0000_2000, 24'hFF_FFFE, '0, 4'b0000);
    expect_out("R6 self-loop", 32'h0000_2000, 1, 0);
  endtask

  task automatic t_rel_R1();
    drive(4'd1, 32'h0000_0100, 24'd1, '0, 0);
    expect_out("R1 plus1", 32'h0000_010C, 1, 0);
    drive(4'd1, 32'h0000_0100, 24'hFF_FFFD, '0, 0);
    expect_out("R1 minus3", 32'h0000_00FC, 1, 0);
    drive(4'd1, 32'h4000_0000, 24'h7F_FFFF, '0, 0);
    expect_out("R1 maxpos", exp_rel(32'h4000_0000, 24'h7F_FFFF), 1, 0);
    drive(4'd1, 32'h4000_0000, 24'h80_0000, '0, 0);
    expect_out("R1 maxneg", 32'h3E00_0008, 1, 0);
  endtask

  task automatic t_zero_R3();
    drive(4'd2, 32'h500, 24'd10, '0, 4'b0100);
    expect_out("R3 eq z1", exp_rel(32'h500, 24'd10), 1, 0);
    drive(4'd2, 32'h500, 24'd10, '0, 4'b1011);
    expect_out("R3 eq z0 R2", 32'h504, 0, 0);
    drive(4'd3, 32'h500, 24'd10, '0, 4'b0000);
    expect_out("R3 ne z0", exp_rel(32'h500, 24'd10), 1, 0);
    drive(4'd3, 32'h500, 24'd10, '0, 4'b0100);
    expect_out("R3 ne z1 R2", 32'h504, 0, 0);
  endtask

  task automatic t_signed_R4();
    for (int f = 0; f < 16; f++) begin
      logic lt;
      lt = f[3] ^ f[0];
      drive(4'd4, 32'h800, 24'h00_0020, '0, 4'(f));
      expect_out("R4 lt", lt ? exp_rel(32'h800, 24'h20) : 32'h804, lt, 0);
      drive(4'd5, 32'h800, 24'h00_0020, '0, 4'(f));
      expect_out("R4 ge", !lt ? exp_rel(32'h800, 24'h20) : 32'h804, !lt, 0);
    end
  endtask

  task automatic t_carry_R5();
    drive(4'd6, 32'h900, 24'd3, '0, 4'b0010);
    expect_out("R5 hs c1", exp_rel(32'h900, 24'd3), 1, 0);
    drive(4'd6, 32'h900, 24'd3, '0, 4'b1101);
    expect_out("R5 hs c0", 32'h904, 0, 0);
    drive(4'd7, 32'h900, 24'd3, '0, 4'b1101);
    expect_out("R5 lo c0", exp_rel(32'h900, 24'd3), 1, 0);
    drive(4'd7, 32'h900, 24'd3, '0, 4'b0010);
    expect_out("R5 lo c1", 32'h904, 0, 0);
  endtask

  task automatic t_link_R7();
    drive(4'd8, 32'h0001_0000, 24'hFF_FFF0, '0, 4'b0000);
    expect_out("R7 bl", 32'h0000_FFC8, 1, 1);
    chk("R7 link_val", link_val, 32'h0001_0004);
    for (int k = 0; k < 16; k++) begin
      if (k == 8) continue;
      drive(4'(k), 32'h0001_0000, 24'd0, 32'h44, 4'b0100);
      chk("R7 no link", {31'd0, link_we}, 32'd0);
    end
  endtask

  task automatic t_jreg_R8();
    drive(4'd9, 32'h100, 24'd77, 32'hDEAD_BEEF, 4'b0000);
    expect_out("R8 jr mask", 32'hDEAD_BEEC, 1, 0);
    drive(4'd9, 32'h100, 24'hFF_FFFF, 32'h0000_3002, 4'b1111);
    expect_out("R8 jr flags", 32'h0000_3000, 1, 0);
  endtask

  task automatic t_none_R9();
    for (int f = 0; f < 16; f++) begin
      drive(4'd0, 32'h0000_0A00, 24'd9, 32'h55, 4'(f));
      expect_out("R9 code0", 32'h0000_0A04, 0, 0);
    end
    for (int k = 10; k < 16; k++) begin
      drive(4'(k), 32'h0000_0A00, 24'd9, 32'h55, 4'b0100);
      expect_out("R9 undef", 32'h0000_0A04, 0, 0);
    end
  endtask

  task automatic t_wrap_R10();
    drive(4'd0, 32'hFFFF_FFFC, 24'd0, '0, 0);
    expect_out("R10 seq wrap", 32'h0000_0000, 0, 0);
    drive(4'd1, 32'hFFFF_FFF8, 24'd2, '0, 0);
    expect_out("R10 rel wrap", 32'h0000_0008, 1, 0);
    drive(4'd1, 32'h0000_0004, 24'hFF_FFFC, '0, 0);
    expect_out("R10 rel under", 32'hFFFF_FFFC, 1, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_always_R6();
    t_rel_R1();
    t_zero_R3();
    t_signed_R4();
    t_carry_R5();
    t_link_R7();
    t_jreg_R8();
    t_none_R9();
    t_wrap_R10();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule